// File: doc/BRIEF.md
# Zone Password Lock with Voted Configuration Pointer

This block guards one protection zone of on-chip memory. After reset it runs a short boot sequence over a read port into a one-time-programmable store. It first fetches three independently stored link pointers and merges them bit by bit with a 2-of-3 majority. The merged value selects which 128-bit zone password to load. The password is held internally as four 32-bit words.

The block powers up locked. Software unlocks it in two steps. First it reads each of the four password registers. These reads only record progress and return zero while the zone is locked. Then it writes the matching word into each of the four key registers. If the loaded password is all ones, the four reads alone unlock the zone.

While the zone is locked, an access to protected memory is granted only when the requesting code itself runs from protected memory. A refused read returns zero and a refused write never reaches the memory. Once unlocked, the zone stays open until the next reset.

Top module: `zone_pw_lock`

## Requirements
- R1: After reset `secure` is 1. It stays 1 at least until the boot load has finished and a complete unlock sequence has been seen.
- R2: The boot sequence reads the link pointers from OTP word addresses 0, 1 and 2, in that order. The OTP returns data the cycle after `otp_rd`. Each pointer is bits [1:0] of its word. The selection is the per-bit 2-of-3 majority of the three pointers.
- R3: With selection s, the boot sequence reads OTP words 16+4*s+i for i = 0..3, in that order. Word i becomes password register i, giving a 128-bit password.
- R4: Bus addresses 0..3 are password registers and 4..7 are key registers. A bus read gives its data on `bus_rdata` after the next clock edge. Password register i reads as 0 while locked and as password word i once unlocked. Key registers always read as 0.
- R5: The zone unlocks when all four password registers have been read and then each key register i has been written with password word i. `secure` falls at the clock edge that takes the last required access.
- R6: A key write, made after all four reads, whose data differs from its password word leaves the zone locked and clears all read progress and key matches. The whole sequence must then restart.
- R7: Key writes made before all four password reads have been recorded are ignored. They neither count as matches nor clear progress.
- R8: If all 128 password bits are 1, the zone unlocks at the edge that records the last of the four distinct password reads, with no key writes. Repeated reads of the same register do not count twice.
- R9: Password reads made before the boot load finishes are not recorded.
- R10: Once unlocked, the zone stays unlocked until reset, whatever is written to the key registers.
- R11: `grant` = !`acc_tgt_secure` | `acc_from_secure` | !`secure`. `acc_rdata` equals `mem_rdata` only when `acc_rd` and `grant` are both 1, and is 0 otherwise. `mem_wr_en` = `acc_wr` & `grant`.
- R12: Exactly seven OTP reads are issued after reset, each a single-cycle pulse, and none after the load completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| otp_rd | output | 1 | OTP read request |
| otp_addr | output | OTP_AW | OTP word address |
| otp_rdata | input | 32 | OTP read data, valid the cycle after the request |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (registered) |
| acc_rd | input | 1 | Protected-path read request |
| acc_wr | input | 1 | Protected-path write request |
| acc_tgt_secure | input | 1 | Access targets protected memory |
| acc_from_secure | input | 1 | Requesting code executes from protected memory |
| mem_rdata | input | 32 | Data returned by memory |
| acc_rdata | output | 32 | Gated read data to the requester |
| mem_wr_en | output | 1 | Gated write enable to memory |
| grant | output | 1 | Access allowed |
| secure | output | 1 | 1 while the zone is locked |

## Verification
Assertions check several properties on every cycle. The zone stays locked until the load completes, and unlocking is permanent and requires full read progress. A refused access is never leaked or written. The OTP requests are single-cycle pulses that stop after the load. A mismatching key write empties the progress record on the following cycle.

Only the bench scenarios can show that the majority vote picks the right password set, observed through which key values unlock. They also show that early key writes neither count nor clear progress, and that duplicate reads do not stand in for a missing one. The blank-password shortcut and the readback of password words after unlock are likewise covered only by the scenarios.

// File: rtl/zpl_pkg.sv
package zpl_pkg;

    localparam int WORD_W     = 32;
    localparam int PW_W       = 128;
    localparam int PW_WORDS   = PW_W / WORD_W;      // must be a power of two
    localparam int PW_IDX_W   = $clog2(PW_WORDS);
    localparam int PTR_W      = 2;
    localparam int LINK_CNT   = 3;
    localparam int REG_AW     = 4;
    localparam int BOOT_STEPS = LINK_CNT + PW_WORDS;
    localparam int STEP_W     = $clog2(BOOT_STEPS);

    typedef logic [WORD_W-1:0]                 word_t;
    typedef logic [PTR_W-1:0]                  ptr_t;
    typedef logic [PW_WORDS-1:0][WORD_W-1:0]   pw_arr_t;

    typedef enum logic [1:0] {
        BL_ISSUE   = 2'd0,
        BL_CAPTURE = 2'd1,
        BL_DONE    = 2'd2
    } boot_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic tgt_sec;
        logic from_sec;
    } acc_req_t;

    // Per-bit 2-of-3 majority
    function automatic ptr_t vote3(ptr_t a, ptr_t b, ptr_t c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic all_ones(pw_arr_t pw);
        return &pw;
    endfunction

endpackage

// File: rtl/zpl_boot_loader.sv
module zpl_boot_loader
    import zpl_pkg::*;
#(
    parameter int OTP_AW    = 8,
    parameter int LINK_BASE = 0,
    parameter int PW_BASE   = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic              otp_rd,
    output logic [OTP_AW-1:0] otp_addr,
    input  word_t             otp_rdata,
    output logic              loaded,
    output pw_arr_t           pw,
    output logic              blank
);

    boot_state_e       state_q;
    logic [STEP_W-1:0] step_q;
    ptr_t              link_q [LINK_CNT];
    pw_arr_t           pw_q;
    ptr_t              sel;
    logic              in_link;

    assign sel     = vote3(link_q[0], link_q[1], link_q[2]);
    assign in_link = step_q < STEP_W'(LINK_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BL_ISSUE;
            step_q  <= '0;
        end else begin
            case (state_q)
                BL_ISSUE:   state_q <= BL_CAPTURE;
                BL_CAPTURE: begin
                    if (step_q == STEP_W'(BOOT_STEPS - 1)) begin
                        state_q <= BL_DONE;
                    end else begin
                        step_q  <= step_q + 1'b1;
                        state_q <= BL_ISSUE;
                    end
                end
                default:    state_q <= BL_DONE;
            endcase
        end
    end

    always_comb begin
        otp_rd = (state_q == BL_ISSUE);
        if (in_link) begin
            otp_addr = OTP_AW'(LINK_BASE) + OTP_AW'(step_q);
        end else begin
            otp_addr = OTP_AW'(PW_BASE) + OTP_AW'(sel) * OTP_AW'(PW_WORDS)
                     + OTP_AW'(step_q - STEP_W'(LINK_CNT));
        end
    end

    for (genvar g = 0; g < LINK_CNT; g++) begin : g_link
        always_ff @(posedge clk) begin
            if (rst) begin
                link_q[g] <= '0;
            end else if (state_q == BL_CAPTURE && step_q == STEP_W'(g)) begin
                link_q[g] <= otp_rdata[PTR_W-1:0];
            end
        end
    end

    for (genvar g = 0; g < PW_WORDS; g++) begin : g_pw
        always_ff @(posedge clk) begin
            if (rst) begin
                pw_q[g] <= '0;
            end else if (state_q == BL_CAPTURE && step_q == STEP_W'(LINK_CNT + g)) begin
                pw_q[g] <= otp_rdata;
            end
        end
    end

    assign loaded = (state_q == BL_DONE);
    assign pw     = pw_q;
    assign blank  = all_ones(pw_q);

    // R12
    otp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        otp_rd |=> !otp_rd);

    // R12
    otp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        loaded |-> !otp_rd);

endmodule

// File: rtl/zpl_unlock_seq.sv
module zpl_unlock_seq
    import zpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              loaded,
    input  pw_arr_t           pw,
    input  logic              blank,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  word_t             bus_wdata,
    output word_t             bus_rdata,
    output logic              unlocked
);

    logic [PW_WORDS-1:0] rd_seen_q, rd_seen_d;
    logic [PW_WORDS-1:0] key_ok_q, key_ok_d;
    logic                unlocked_q, unlocked_d;
    word_t               rdata_q;
    logic                is_pw, is_key, key_miss;
    logic [PW_IDX_W-1:0] idx;

    assign is_pw  = bus_addr < REG_AW'(PW_WORDS);
    assign is_key = !is_pw && (bus_addr < REG_AW'(2 * PW_WORDS));
    assign idx    = PW_IDX_W'(bus_addr);   // word count is a power of two
    assign key_miss = loaded && !unlocked_q && bus_en && bus_we && is_key
                   && (&rd_seen_q) && (bus_wdata != pw[idx]);

    always_comb begin
        rd_seen_d = rd_seen_q;
        key_ok_d  = key_ok_q;
        if (loaded && !unlocked_q && bus_en) begin
            if (!bus_we && is_pw) begin
                rd_seen_d[idx] = 1'b1;
            end
            if (bus_we && is_key && (&rd_seen_q)) begin
                if (bus_wdata == pw[idx]) begin
                    key_ok_d[idx] = 1'b1;
                end else begin
                    rd_seen_d = '0;
                    key_ok_d  = '0;
                end
            end
        end
        unlocked_d = unlocked_q
                   | (loaded & (&rd_seen_d) & ((&key_ok_d) | blank));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_seen_q  <= '0;
            key_ok_q   <= '0;
            unlocked_q <= 1'b0;
            rdata_q    <= '0;
        end else begin
            rd_seen_q  <= rd_seen_d;
            key_ok_q   <= key_ok_d;
            unlocked_q <= unlocked_d;
            if (bus_en && !bus_we) begin
                rdata_q <= (unlocked_q && is_pw) ? pw[idx] : '0;
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign unlocked  = unlocked_q;

    // R10
    unlock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        unlocked_q |=> unlocked_q);

    // R5
    unlock_needs_reads_chk: assert property (@(posedge clk) disable iff (rst)
        unlocked_q |-> (&rd_seen_q));

    // R9
    no_early_progress_chk: assert property (@(posedge clk) disable iff (rst)
        !loaded |-> (rd_seen_q == '0));

    // R6
    key_miss_clears_chk: assert property (@(posedge clk) disable iff (rst)
        key_miss |=> (rd_seen_q == '0 && key_ok_q == '0 && !unlocked_q));

endmodule

// File: rtl/zpl_access_gate.sv
module zpl_access_gate
    import zpl_pkg::*;
(
    input  logic  secure,
    input  logic  acc_rd,
    input  logic  acc_wr,
    input  logic  acc_tgt_secure,
    input  logic  acc_from_secure,
    input  word_t mem_rdata,
    output word_t acc_rdata,
    output logic  mem_wr_en,
    output logic  grant
);

    acc_req_t req;

    assign req = '{rd: acc_rd, wr: acc_wr,
                   tgt_sec: acc_tgt_secure, from_sec: acc_from_secure};

    always_comb begin
        grant     = !req.tgt_sec || req.from_sec || !secure;
        acc_rdata = (req.rd && grant) ? mem_rdata : '0;
        mem_wr_en = req.wr && grant;
    end

endmodule

// File: rtl/zone_pw_lock.sv
module zone_pw_lock
    import zpl_pkg::*;
#(
    parameter int OTP_AW    = 8,
    parameter int LINK_BASE = 0,
    parameter int PW_BASE   = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic              otp_rd,
    output logic [OTP_AW-1:0] otp_addr,
    input  logic [31:0]       otp_rdata,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              acc_tgt_secure,
    input  logic              acc_from_secure,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       acc_rdata,
    output logic              mem_wr_en,
    output logic              grant,
    output logic              secure
);

    logic    loaded;
    logic    blank;
    logic    unlocked;
    pw_arr_t pw;

    zpl_boot_loader #(
        .OTP_AW   (OTP_AW),
        .LINK_BASE(LINK_BASE),
        .PW_BASE  (PW_BASE)
    ) u_boot (
        .clk      (clk),
        .rst      (rst),
        .otp_rd   (otp_rd),
        .otp_addr (otp_addr),
        .otp_rdata(otp_rdata),
        .loaded   (loaded),
        .pw       (pw),
        .blank    (blank)
    );

    zpl_unlock_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .loaded   (loaded),
        .pw       (pw),
        .blank    (blank),
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .unlocked (unlocked)
    );

    assign secure = !unlocked;

    zpl_access_gate u_gate (
        .secure         (secure),
        .acc_rd         (acc_rd),
        .acc_wr         (acc_wr),
        .acc_tgt_secure (acc_tgt_secure),
        .acc_from_secure(acc_from_secure),
        .mem_rdata      (mem_rdata),
        .acc_rdata      (acc_rdata),
        .mem_wr_en      (mem_wr_en),
        .grant          (grant)
    );

    // R1
    secure_until_boot_chk: assert property (@(posedge clk) disable iff (rst)
        !loaded |-> secure);

    // R11
    blocked_access_chk: assert property (@(posedge clk) disable iff (rst)
        (secure && acc_tgt_secure && !acc_from_secure)
            |-> (!grant && !mem_wr_en && acc_rdata == '0));

endmodule

// File: tb/zone_pw_lock_tb.sv
module zone_pw_lock_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        otp_rd;
    logic [7:0]  otp_addr;
    logic [31:0] otp_rdata = '0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        acc_rd = 1'b0, acc_wr = 1'b0;
    logic        acc_tgt_secure = 1'b0, acc_from_secure = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] acc_rdata;
    logic        mem_wr_en, grant, secure;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    zone_pw_lock u_dut (
        .clk(clk), .rst(rst),
        .otp_rd(otp_rd), .otp_addr(otp_addr), .otp_rdata(otp_rdata),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_tgt_secure(acc_tgt_secure), .acc_from_secure(acc_from_secure),
        .mem_rdata(mem_rdata), .acc_rdata(acc_rdata),
        .mem_wr_en(mem_wr_en), .grant(grant), .secure(secure)
    );

    // OTP model with request log
    logic [31:0] otp_mem [0:31];
    logic [7:0]  log_addr [0:7];
    int          log_cnt = 0;
    logic        log_clr = 1'b0;

    always @(posedge clk) begin
        if (log_clr) begin
            log_cnt <= 0;
        end else if (otp_rd) begin
            otp_rdata <= otp_mem[otp_addr[4:0]];
            if (log_cnt < 8) log_addr[log_cnt] <= otp_addr;
            log_cnt <= log_cnt + 1;
        end
    end

    function automatic logic [31:0] pw_word(int set, int i);
        return 32'h5A00_003C | (32'(set) << 16) | (32'(i) << 8);
    endfunction

    typedef struct packed {
        logic        we;
        logic [3:0]  addr;
        logic [31:0] data;
        logic        exp_sec;
        logic [31:0] exp_rd;
    } vec_t;

    // Selection 1 scenario
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd4, pw_word(1,0),   1'b1, 32'h0},          // R7 early key ignored
        '{1'b0, 4'd0, 32'h0,          1'b1, 32'h0},          // R4 locked read zero
        '{1'b0, 4'd1, 32'h0,          1'b1, 32'h0},
        '{1'b0, 4'd2, 32'h0,          1'b1, 32'h0},
        '{1'b1, 4'd5, 32'hDEAD_BEEF,  1'b1, 32'h0},          // R7 early miss ignored
        '{1'b1, 4'd4, pw_word(1,0),   1'b1, 32'h0},          // R7
        '{1'b0, 4'd3, 32'h0,          1'b1, 32'h0},
        '{1'b1, 4'd4, pw_word(1,0),   1'b1, 32'h0},          // R5 keys
        '{1'b1, 4'd5, pw_word(1,1),   1'b1, 32'h0},
        '{1'b1, 4'd6, pw_word(1,2),   1'b1, 32'h0},
        '{1'b1, 4'd7, pw_word(1,3),   1'b0, 32'h0},          // R5 unlock
        '{1'b0, 4'd2, 32'h0,          1'b0, pw_word(1,2)},   // R4 readback
        '{1'b0, 4'd5, 32'h0,          1'b0, 32'h0},          // R4 key reads zero
        '{1'b1, 4'd4, 32'h0BAD_0BAD,  1'b0, 32'h0},          // R10 stays open
        '{1'b0, 4'd0, 32'h0,          1'b0, pw_word(1,0)}    // R4
    };

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input int p0, input int p1, input int p2, input bit blank3);
        for (int a = 0; a < 32; a++) otp_mem[a] = 32'hFFFF_FFFF;
        otp_mem[0] = 32'hABCD_EF00 | 32'(p0);
        otp_mem[1] = 32'hABCD_EF00 | 32'(p1);
        otp_mem[2] = 32'hABCD_EF00 | 32'(p2);
        for (int s = 0; s < 4; s++)
            for (int i = 0; i < 4; i++)
                otp_mem[16 + 4*s + i] = (blank3 && s == 3) ? 32'hFFFF_FFFF : pw_word(s, i);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; log_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0; log_clr = 1'b0;
    endtask

    task automatic boot_chk(input int sel);
        repeat (20) @(negedge clk);
        chk(log_cnt == 7, "R12", "otp read count", 32'(log_cnt), 32'd7);
        for (int i = 0; i < 3; i++)
            chk(log_addr[i] == 8'(i), "R2", "link addr", 32'(log_addr[i]), 32'(i));
        for (int i = 0; i < 4; i++)
            chk(log_addr[3+i] == 8'(16 + 4*sel + i), "R3", "pw addr",
                32'(log_addr[3+i]), 32'(16 + 4*sel + i));
    endtask

    task automatic bus_op(input logic we, input logic [3:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic acc_chk(input logic tgt, input logic from, input logic exp_sec);
        logic eg;
        acc_rd = 1'b1; acc_wr = 1'b1; acc_tgt_secure = tgt; acc_from_secure = from;
        mem_rdata = 32'h1234_5678;
        #2;
        eg = !tgt || from || !exp_sec;
        chk(grant == eg, "R11", "grant", 32'(grant), 32'(eg));
        chk(mem_wr_en == eg, "R11", "mem_wr_en", 32'(mem_wr_en), 32'(eg));
        chk(acc_rdata == (eg ? 32'h1234_5678 : 32'h0), "R11", "acc_rdata",
            acc_rdata, eg ? 32'h1234_5678 : 32'h0);
        acc_rd = 1'b0; acc_wr = 1'b0;
        #2;
        chk(acc_rdata == 32'h0 && mem_wr_en == 1'b0, "R11", "idle gate",
            acc_rdata, 32'h0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // Scenario A: pointers 1,3,0 -> selection 1 (R2)
        cfg(1, 3, 0, 1'b0);
        do_reset();
        chk(secure == 1'b1, "R1", "secure after reset", 32'(secure), 32'd1);
        boot_chk(1);
        chk(secure == 1'b1, "R1", "secure after boot", 32'(secure), 32'd1);
        acc_chk(1'b1, 1'b0, 1'b1);
        acc_chk(1'b1, 1'b1, 1'b1);
        acc_chk(1'b0, 1'b0, 1'b1);
        for (int k = 0; k < NV; k++) begin
            bus_op(VEC[k].we, VEC[k].addr, VEC[k].data);
            chk(secure == VEC[k].exp_sec, "R5", $sformatf("vec %0d secure", k),
                32'(secure), 32'(VEC[k].exp_sec));
            if (!VEC[k].we)
                chk(bus_rdata == VEC[k].exp_rd, "R4", $sformatf("vec %0d rdata", k),
                    bus_rdata, VEC[k].exp_rd);
        end
        acc_chk(1'b1, 1'b0, 1'b0);   // R11 open zone

        // Scenario B: pointers 2,3,1 -> selection 3, blank password (R8, R9)
        cfg(2, 3, 1, 1'b1);
        do_reset();
        chk(secure == 1'b1, "R1", "secure after re-reset", 32'(secure), 32'd1);
        for (int i = 0; i < 4; i++) bus_op(1'b0, 4'(i), 32'h0);   // during boot
        boot_chk(3);
        chk(secure == 1'b1, "R9", "reads during boot ignored", 32'(secure), 32'd1);
        for (int i = 0; i < 3; i++) bus_op(1'b0, 4'(i), 32'h0);
        bus_op(1'b0, 4'd1, 32'h0);
        chk(secure == 1'b1, "R8", "duplicate read not counted", 32'(secure), 32'd1);
        bus_op(1'b0, 4'd3, 32'h0);
        chk(secure == 1'b0, "R8", "blank unlock on reads", 32'(secure), 32'd1 ^ 32'd1);
        bus_op(1'b0, 4'd3, 32'h0);
        chk(bus_rdata == 32'hFFFF_FFFF, "R3", "blank word readback",
            bus_rdata, 32'hFFFF_FFFF);

        // Scenario C: pointers 0,2,1 -> selection 0, mismatch restart (R6)
        cfg(0, 2, 1, 1'b0);
        do_reset();
        boot_chk(0);
        for (int i = 0; i < 4; i++) bus_op(1'b0, 4'(i), 32'h0);
        bus_op(1'b1, 4'd4, pw_word(0, 0));
        bus_op(1'b1, 4'd5, pw_word(0, 0));   // wrong word
        chk(secure == 1'b1, "R6", "mismatch keeps lock", 32'(secure), 32'd1);
        for (int i = 0; i < 4; i++) bus_op(1'b1, 4'(4 + i), pw_word(0, i));
        chk(secure == 1'b1, "R6", "progress cleared by mismatch", 32'(secure), 32'd1);
        acc_chk(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) bus_op(1'b0, 4'(i), 32'h0);
        chk(secure == 1'b1, "R5", "reads alone do not unlock", 32'(secure), 32'd1);
        for (int i = 0; i < 4; i++) bus_op(1'b1, 4'(4 + i), pw_word(0, i));
        chk(secure == 1'b0, "R6", "restarted sequence unlocks", 32'(secure), 32'd0);
        bus_op(1'b0, 4'd1, 32'h0);
        chk(bus_rdata == pw_word(0, 1), "R4", "readback sel 0",
            bus_rdata, pw_word(0, 1));
        repeat (5) @(negedge clk);
        chk(secure == 1'b0, "R10", "stays unlocked", 32'(secure), 32'd0);
        finish_run();
    end

endmodule